// File: doc/BRIEF.md
# Receive Slot Packer for a Serial Audio Link

This block sits between the deframer of a time-slotted serial audio link and the receive FIFO of one channel. The deframer presents a whole frame at once: a flag per slot telling whether that slot carried data, and a 20-bit field per slot. The packer keeps only the slots that are enabled for this channel, that carried data, and that no lower-numbered channel has already claimed. It then trims each kept sample to the configured width and writes 32-bit words out, one slot per clock cycle.

A two-bit size code picks a sample width of 12, 16, 18 or 20 bits. The sample sits at the top of the 20-bit field, so narrower widths drop the low-order padding. For the two short widths a compact bit can pack two samples into one word. Otherwise every sample gets a word of its own, right-justified. A stall input from the FIFO side pauses slot consumption without losing data. A busy output tells the deframer when the next frame can be handed over.

Top module: `rxslot_packer`

## Requirements
- R1: The size code gives the sample width as 2'b00 = 12 bits, 2'b01 = 18 bits, 2'b10 = 20 bits and 2'b11 = 16 bits. The sample is the top W bits of the 20-bit slot field, slot_data[20*s+19 -: W] for slot s, and the low 20-W bits are discarded.
- R2: When the width is 12 or 16 and compact is 0, each sample makes one word, right-justified in bits [W-1:0], with all upper bits zero.
- R3: When the width is 18 or 20, the compact input has no effect and each sample makes one right-justified word with zero upper bits.
- R4: When the width is 12 or 16 and compact is 1, two consecutive samples make one word. The earlier sample goes in bits [15:0] and the later one in bits [31:16], and each is zero-extended to 16 bits.
- R5: In compact layout, an odd sample left at the end of a frame is held. It becomes the low half of the word completed by the first compact sample of a later frame.
- R6: Within a frame, the selected slots are emitted in ascending slot number, one slot per unstalled cycle.
- R7: Slot s is selected only when slot_tag[s]=1, slot_en[s]=1 and slot_claim[s]=0. slot_claim[s]=1 means a lower-numbered channel owns the slot.
- R8: word_vld is high for exactly one cycle per completed word and stays low while no frame is in progress.
- R9: While out_stall is high, no slot is consumed and word_vld is low in the following cycle. Every stalled slot is emitted later.
- R10: A frame is captured on a cycle with frame_in=1 and frame_busy=0. frame_busy stays high while selected slots remain, and frame_in is ignored while frame_busy is high.
- R11: After reset, word_vld and frame_busy are 0 and no half-word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| frame_in | input | 1 | Frame offered for capture |
| slot_tag | input | 13 | Per-slot flag: slot carried data this frame |
| slot_en | input | 13 | Per-slot enable for this channel |
| slot_claim | input | 13 | Per-slot flag: a lower channel already owns the slot |
| slot_data | input | 260 | Slot fields, slot s at bits [20*s+19:20*s] |
| size_code | input | 2 | Sample width code |
| compact | input | 1 | Pack two short samples per word |
| out_stall | input | 1 | Back-pressure from the FIFO side |
| frame_busy | output | 1 | Selected slots of the captured frame still pending |
| word_vld | output | 1 | One-cycle strobe for a completed word |
| word_dat | output | 32 | Completed word |

## Verification
The assertions assume that the slot flags, data, size code and compact bit are only sampled on the capture cycle. They also assume that the size code and compact bit do not switch away from compact layout while a half-word is held, because a held half is kept until a later compact sample arrives. The stimulus changes configuration only between frames. Every compact frame sequence in the stimulus either leaves no half pending or is followed by another compact frame of the same width. Stall patterns come from a free-running shift register, so stalls land both on the first slot of a frame and in the middle of it.

// File: rtl/rxslot_pkg.sv
package rxslot_pkg;

  typedef enum logic [1:0] {
    SZ12 = 2'b00,
    SZ18 = 2'b01,
    SZ20 = 2'b10,
    SZ16 = 2'b11
  } size_e;

  function automatic logic size_is_short(input size_e sz);
    return (sz == SZ12) || (sz == SZ16);
  endfunction

endpackage

// File: rtl/rxslot_pick.sv
module rxslot_pick #(
  parameter int NSLOT = 13
) (
  input  logic [NSLOT-1:0] mask,
  output logic [NSLOT-1:0] onehot
);

  always_comb begin
    onehot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (mask[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxslot_fit.sv
module rxslot_fit
  import rxslot_pkg::*;
#(
  parameter int SLOT_W = 20
) (
  input  logic [SLOT_W-1:0] raw,
  input  size_e             size,
  output logic [SLOT_W-1:0] sample
);

  localparam int PAD12 = SLOT_W - 12;
  localparam int PAD16 = SLOT_W - 16;
  localparam int PAD18 = SLOT_W - 18;

  always_comb begin
    unique case (size)
      SZ12:    sample = raw >> PAD12;
      SZ16:    sample = raw >> PAD16;
      SZ18:    sample = raw >> PAD18;
      default: sample = raw;
    endcase
  end

endmodule

// File: rtl/rxslot_wordpack.sv
module rxslot_wordpack #(
  parameter int SLOT_W = 20,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              pair_mode,
  input  logic [SLOT_W-1:0] sample,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_dat
);

  localparam int HALF_W = WORD_W / 2;
  localparam int FILL_W = WORD_W - SLOT_W;

  logic              vld_d;
  logic [WORD_W-1:0] dat_d;
  logic [HALF_W-1:0] hold_q, hold_d;
  logic              hold_v_q, hold_v_d;

  always_comb begin
    vld_d    = 1'b0;
    dat_d    = word_dat;
    hold_d   = hold_q;
    hold_v_d = hold_v_q;
    if (take) begin
      if (pair_mode) begin
        if (hold_v_q) begin
          vld_d    = 1'b1;
          dat_d    = {sample[HALF_W-1:0], hold_q};
          hold_v_d = 1'b0;
        end else begin
          hold_d   = sample[HALF_W-1:0];
          hold_v_d = 1'b1;
        end
      end else begin
        vld_d = 1'b1;
        dat_d = {{FILL_W{1'b0}}, sample};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_vld <= 1'b0;
      word_dat <= '0;
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else begin
      word_vld <= vld_d;
      if (vld_d) word_dat <= dat_d;
      if (take) begin
        hold_q   <= hold_d;
        hold_v_q <= hold_v_d;
      end
    end
  end

  AST_PAIR_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    take && pair_mode && hold_v_q |=> word_vld && (word_dat[HALF_W-1:0] == $past(hold_q))); // R4
  AST_FIRST_HALF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    take && pair_mode && !hold_v_q |=> !word_vld); // R5
  AST_SEP_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take && !pair_mode |=> word_vld && (word_dat[WORD_W-1:SLOT_W] == '0)); // R2

endmodule

// File: rtl/rxslot_packer.sv
module rxslot_packer
  import rxslot_pkg::*;
#(
  parameter int NSLOT  = 13,
  parameter int SLOT_W = 20,
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_in,
  input  logic [NSLOT-1:0]        slot_tag,
  input  logic [NSLOT-1:0]        slot_en,
  input  logic [NSLOT-1:0]        slot_claim,
  input  logic [NSLOT*SLOT_W-1:0] slot_data,
  input  logic [1:0]              size_code,
  input  logic                    compact,
  input  logic                    out_stall,
  output logic                    frame_busy,
  output logic                    word_vld,
  output logic [WORD_W-1:0]       word_dat
);

  localparam int DATA_W = NSLOT * SLOT_W;

  logic [NSLOT-1:0]  mask_q, mask_d;
  logic [DATA_W-1:0] dat_q;
  size_e             size_q;
  logic              cmp_q;
  logic              accept, step, pair_mode;
  logic [NSLOT-1:0]  pick_oh;
  logic [SLOT_W-1:0] picked, sample;

  assign frame_busy = |mask_q;
  assign accept     = frame_in && !frame_busy;
  assign step       = frame_busy && !out_stall;
  assign pair_mode  = cmp_q && size_is_short(size_q);

  rxslot_pick #(.NSLOT(NSLOT)) u_pick (
    .mask   (mask_q),
    .onehot (pick_oh)
  );

  always_comb begin
    picked = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (pick_oh[s]) picked = picked | dat_q[s*SLOT_W +: SLOT_W];
    end
  end

  rxslot_fit #(.SLOT_W(SLOT_W)) u_fit (
    .raw    (picked),
    .size   (size_q),
    .sample (sample)
  );

  rxslot_wordpack #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (step),
    .pair_mode (pair_mode),
    .sample    (sample),
    .word_vld  (word_vld),
    .word_dat  (word_dat)
  );

  always_comb begin
    mask_d = mask_q;
    if (accept)    mask_d = slot_tag & slot_en & ~slot_claim;
    else if (step) mask_d = mask_q & ~pick_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      dat_q  <= '0;
      size_q <= SZ12;
      cmp_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (accept) begin
        dat_q  <= slot_data;
        size_q <= size_e'(size_code);
        cmp_q  <= compact;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_busy |=> !word_vld); // R8
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_busy && out_stall |=> $stable(mask_q) && !word_vld); // R9
  AST_ONE_SLOT_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_busy && !out_stall |=> ($countones(mask_q) + 1 == $countones($past(mask_q)))); // R6
  AST_CLAIM_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_in && !frame_busy |=> ((mask_q & $past(slot_claim)) == '0)); // R7
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_busy && frame_in |=> ((mask_q & ~$past(mask_q)) == '0)); // R10

endmodule

// File: tb/sim_rxslot_packer.sv
module sim_rxslot_packer;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT  = 13;
  localparam int SLOT_W = 20;

  typedef struct {
    logic [31:0] w;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_in;
  logic [NSLOT-1:0] slot_tag, slot_en, slot_claim;
  logic [NSLOT*SLOT_W-1:0] slot_data;
  logic [1:0] size_code;
  logic compact, out_stall;
  logic frame_busy, word_vld;
  logic [31:0] word_dat;

  int checks = 0;
  int failures = 0;
  exp_t q[$];
  logic [15:0] m_hold;
  bit m_hold_v = 0;
  bit stall_mode = 0;
  bit mon_on = 0;
  logic [7:0] lfsr = 8'hA7;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxslot_packer u0 (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_in), .slot_tag(slot_tag),
    .slot_en(slot_en), .slot_claim(slot_claim), .slot_data(slot_data),
    .size_code(size_code), .compact(compact), .out_stall(out_stall),
    .frame_busy(frame_busy), .word_vld(word_vld), .word_dat(word_dat)
  );

  function automatic logic [19:0] gen(input int seed, input int s);
    return 20'((seed * 32'h9E37 + s * 32'h3B1) ^ 32'h5A5A5);
  endfunction

  function automatic int width_of(input logic [1:0] sz);
    case (sz)
      2'b00: return 12;
      2'b01: return 18;
      2'b10: return 20;
      default: return 16;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: computes expected words, then offers the frame
  task automatic send_frame(input logic [NSLOT-1:0] tag, input logic [NSLOT-1:0] en,
                            input logic [NSLOT-1:0] claim, input logic [1:0] sz,
                            input bit cmp, input int seed, input string req);
    int w;
    logic [19:0] smp;
    exp_t e;
    while (frame_busy) @(negedge clk);
    w = width_of(sz);
    for (int s = 0; s < NSLOT; s++) begin
      slot_data[s*SLOT_W +: SLOT_W] = gen(seed, s);
      if (tag[s] && en[s] && !claim[s]) begin
        smp = gen(seed, s) >> (20 - w);
        if (cmp && (sz == 2'b00 || sz == 2'b11)) begin
          if (m_hold_v) begin
            e.w = {smp[15:0], m_hold}; e.req = req; q.push_back(e);
            m_hold_v = 0;
          end else begin
            m_hold = smp[15:0]; m_hold_v = 1;
          end
        end else begin
          e.w = {12'h000, smp}; e.req = req; q.push_back(e);
        end
      end
    end
    slot_tag = tag; slot_en = en; slot_claim = claim;
    size_code = sz; compact = cmp; frame_in = 1'b1;
    @(negedge clk);
    frame_in = 1'b0;
  endtask

  // Stall generator, updated away from the sampling edge
  initial begin
    out_stall = 1'b0;
    forever begin
      @(negedge clk);
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_stall <= stall_mode ? (lfsr[0] | lfsr[2]) : 1'b0;
    end
  end

  // Monitor: pops and compares words as they appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (out_stall && word_vld) check(1'b0, "R9 word after stall", word_dat, 32'h0);
        if (word_vld) begin
          if (q.size() == 0) check(1'b0, "R8 unexpected word", word_dat, 32'h0);
          else begin
            e = q.pop_front();
            check(word_dat === e.w, e.req, word_dat, e.w);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_in = 1'b0; slot_tag = '0; slot_en = '0; slot_claim = '0;
    slot_data = '0; size_code = 2'b00; compact = 1'b0;
    repeat (3) @(negedge clk);
    check(word_vld === 1'b0, "R11 word_vld in reset", {31'b0, word_vld}, 32'h0);
    check(frame_busy === 1'b0, "R11 frame_busy in reset", {31'b0, frame_busy}, 32'h0);
    rst_n = 1'b1;
    mon_on = 1;
    @(negedge clk);

    // R3 R6: 20-bit, compact ignored, slots 3 then 4
    send_frame(13'h1FFF, 13'h0018, 13'h0, 2'b10, 1'b1, 1, "R3");
    // R1 R3: 18-bit separate words
    send_frame(13'h1FFF, 13'h0421, 13'h0, 2'b01, 1'b0, 2, "R1");
    send_frame(13'h1FFF, 13'h0042, 13'h0, 2'b01, 1'b1, 3, "R3");
    // R2: 12-bit and 16-bit separate words
    send_frame(13'h1FFF, 13'h0222, 13'h0, 2'b00, 1'b0, 4, "R2");
    send_frame(13'h1FFF, 13'h1801, 13'h0, 2'b11, 1'b0, 5, "R2");
    // R4 R6: 16-bit compact, four slots give two words
    send_frame(13'h1FFF, 13'h0F00, 13'h0, 2'b11, 1'b1, 6, "R4");
    // R5: 12-bit compact, odd count carried into next frame
    send_frame(13'h1FFF, 13'h0007, 13'h0, 2'b00, 1'b1, 7, "R4");
    send_frame(13'h1FFF, 13'h1000, 13'h0, 2'b00, 1'b1, 8, "R5");
    // R7: missing tags and claimed slots dropped
    send_frame(13'h15AD, 13'h1FFF, 13'h0C0C, 2'b10, 1'b0, 9, "R7");
    // R9: stalls during long frames
    stall_mode = 1;
    send_frame(13'h1FFF, 13'h1FFF, 13'h0, 2'b11, 1'b0, 10, "R9");
    send_frame(13'h1FFF, 13'h0FF0, 13'h0, 2'b00, 1'b1, 11, "R9");
    // R10: frame offered while busy is ignored
    send_frame(13'h1FFF, 13'h1FFF, 13'h0, 2'b01, 1'b0, 12, "R10");
    check(frame_busy === 1'b1, "R10 busy during frame", {31'b0, frame_busy}, 32'h1);
    for (int s = 0; s < NSLOT; s++) slot_data[s*SLOT_W +: SLOT_W] = gen(99, s);
    slot_en = 13'h1FFF; size_code = 2'b10; frame_in = 1'b1;
    @(negedge clk);
    frame_in = 1'b0;
    stall_mode = 0;
    // R7 R8: frame with nothing selected yields no word and no busy
    send_frame(13'h0000, 13'h1FFF, 13'h0, 2'b10, 1'b0, 13, "R8");
    @(negedge clk);
    check(frame_busy === 1'b0, "R8 empty frame not busy", {31'b0, frame_busy}, 32'h0);

    while (frame_busy || q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R9 all words delivered", q.size(), 32'h0);
    check(word_vld === 1'b0, "R8 idle after frames", {31'b0, word_vld}, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule